// File: doc/BRIEF.md
# Baud-Rate Generator Bank

This block holds four independent programmable tick generators that share one clock-enable input. Each generator counts those enables and emits a one-clock tick when a programmed number of them has passed. A 16x-oversampling serial receiver or transmitter uses these ticks as its sampling strobe. An optional fixed divide-by-16 prescaler sits ahead of each generator's 12-bit counter, so slow rates still fit the counter range.

A routing register connects each of four channel tick outputs to any one of the generators. Several channels may share one generator. Writing a generator's configuration word restarts that generator, so a new rate never inherits a partial period from the old one. Each configuration word and the routing word can be read back through a combinational read port.

Top module: `brg_bank`

## Requirements
- R1: After reset every configuration word and the routing word read as zero, and all generator ticks and channel ticks are low.
- R2: Addresses 0 to 3 select the generator configuration words and address 4 selects the routing word. In a generator word, bits [12:1] hold the divide value N minus 1, bit 13 selects the divide-by-16 prescaler and bit 14 enables the generator. Bit 0 and bits [31:15] always read back as zero.
- R3: With the prescaler off, an enabled generator ticks for exactly one clock on every N-th clock-enable. The first tick follows the N-th enable after the configuration write, and it appears in the clock cycle after that enable is sampled.
- R4: With the prescaler on, the tick comes on every 16·N-th clock-enable, and the first one follows the 16·N-th enable after the write.
- R5: A generator whose enable bit is clear produces no tick.
- R6: Clock cycles in which the clock-enable input is low do not advance any generator and produce no tick.
- R7: A write to a generator word reloads that generator's counter and clears its prescaler. The period restarts even in the middle of a count, and the tick is low in the cycle after the write, even when the clock-enable was high during the write.
- R8: In the routing word, bits [2c+1:2c] select the generator that drives channel c, and bits [31:8] read back as zero. Each channel tick equals the tick of its selected generator in the same cycle.
- R9: The generators count independently of one another. One generator's configuration or ticks never change another generator's period.
- R10: Every divide value from 1 (tick on every enable) to 4096 (field value 4095) is honoured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Common clock-enable that the generators count |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address (0-3 generators, 4 routing) |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Combinational read data, reserved bits zero |
| genTick | output | 4 | One-clock tick of each generator |
| chanTick | output | 4 | Routed tick of each channel |

## Verification
The bench builds the block with its defaults: four generators, four channels, a 12-bit counter and a 4-bit prescaler. The full 12-bit counter therefore reaches its top value of 4096 within a few thousand cycles, and with the prescaler a divide value of 3 shows two complete 48-enable periods. Four generators with a 2-bit routing select let every channel point at a different or shared generator. This exposes fan-out and cross-coupling faults.

// File: rtl/brg_pkg.sv
package brg_pkg;
  parameter int GEN_COUNT  = 4;
  parameter int CHAN_COUNT = 4;
  parameter int CNT_W      = 12;
  parameter int PRE_W      = 4;
  parameter int REG_W      = 32;

  localparam int SEL_W   = $clog2(GEN_COUNT);
  localparam int ADDR_W  = $clog2(GEN_COUNT + 1);
  localparam int DIV_LSB = 1;
  localparam int PRE_BIT = DIV_LSB + CNT_W;
  localparam int EN_BIT  = PRE_BIT + 1;

  // writable bits of a generator word: divisor field, prescale and enable
  localparam logic [REG_W-1:0] GEN_MASK   = REG_W'((64'd1 << (EN_BIT + 1)) - 64'd2);
  // writable bits of the routing word: one select per channel
  localparam logic [REG_W-1:0] ROUTE_MASK = REG_W'((64'd1 << (SEL_W * CHAN_COUNT)) - 64'd1);

  typedef logic [CNT_W-1:0] divVal_t;
  typedef logic [SEL_W-1:0] genSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [GEN_COUNT-1:0] reload;   // configuration word written this cycle
    logic [GEN_COUNT-1:0] run;      // enabled and clock-enable present
    logic [GEN_COUNT-1:0] preOn;    // prescaler selected
    divVal_t              loadDiv;  // divisor field of the incoming write
  } brgStrobes_t;
endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output brgStrobes_t       strobes,
  output divVal_t           divisor [GEN_COUNT],
  output genSel_t           routeSel [CHAN_COUNT]
);
  localparam logic [ADDR_W-1:0] ROUTE_ADDR = ADDR_W'(GEN_COUNT);

  logic [REG_W-1:0]     genReg [GEN_COUNT];
  logic [REG_W-1:0]     routeReg;
  logic [GEN_COUNT-1:0] reloadV;
  logic [GEN_COUNT-1:0] runV;
  logic [GEN_COUNT-1:0] preV;

  for (genvar g = 0; g < GEN_COUNT; g++) begin : genCfg
    always_ff @(posedge clk) begin
      if (!rstN)
        genReg[g] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(g))
        genReg[g] <= wrData & GEN_MASK;
    end

    assign reloadV[g] = wrEn && (wrAddr == ADDR_W'(g));
    assign runV[g]    = clkEn && genReg[g][EN_BIT];
    assign preV[g]    = genReg[g][PRE_BIT];
    assign divisor[g] = genReg[g][DIV_LSB +: CNT_W];

    // R2
    cfg_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(wrEn && wrAddr == ADDR_W'(g)) |-> genReg[g] == ($past(wrData) & GEN_MASK));
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      routeReg <= '0;
    else if (wrEn && wrAddr == ROUTE_ADDR)
      routeReg <= wrData & ROUTE_MASK;
  end

  for (genvar c = 0; c < CHAN_COUNT; c++) begin : chanSel
    assign routeSel[c] = routeReg[c*SEL_W +: SEL_W];
  end

  assign strobes = '{reload: reloadV, run: runV, preOn: preV,
                     loadDiv: wrData[DIV_LSB +: CNT_W]};

  always_comb begin
    rdData = '0;
    for (int g = 0; g < GEN_COUNT; g++)
      if (rdAddr == ADDR_W'(g)) rdData = genReg[g];
    if (rdAddr == ROUTE_ADDR) rdData = routeReg;
  end

  // R8
  route_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && wrAddr == ROUTE_ADDR) |-> routeReg == ($past(wrData) & ROUTE_MASK));
endmodule

// File: rtl/brg_datapath.sv
module brg_datapath
  import brg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  brgStrobes_t           strobes,
  input  divVal_t               divisor [GEN_COUNT],
  input  genSel_t               routeSel [CHAN_COUNT],
  output logic [GEN_COUNT-1:0]  genTick,
  output logic [CHAN_COUNT-1:0] chanTick
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  for (genvar g = 0; g < GEN_COUNT; g++) begin : gen
    logic [CNT_W-1:0] cnt;
    logic [PRE_W-1:0] pre;
    logic             stage;
    logic             tickQ;

    // counter advances on every run cycle, or once per prescaler wrap
    assign stage = strobes.run[g] && (!strobes.preOn[g] || pre == PRE_MAX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt   <= '0;
        pre   <= '0;
        tickQ <= 1'b0;
      end else if (strobes.reload[g]) begin
        cnt   <= strobes.loadDiv;
        pre   <= '0;
        tickQ <= 1'b0;
      end else begin
        if (strobes.run[g] && strobes.preOn[g])
          pre <= pre + 1'b1;
        if (stage) begin
          if (cnt == '0) begin
            cnt   <= divisor[g];
            tickQ <= 1'b1;
          end else begin
            cnt   <= cnt - 1'b1;
            tickQ <= 1'b0;
          end
        end else begin
          tickQ <= 1'b0;
        end
      end
    end

    assign genTick[g] = tickQ;

    // R6
    tick_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
      tickQ |-> $past(strobes.run[g]));
    // R7
    no_tick_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobes.reload[g]) |-> !tickQ);
    // R10
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= divisor[g]);
    // R4
    pre_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.preOn[g] |-> pre == '0);
  end

  for (genvar c = 0; c < CHAN_COUNT; c++) begin : chan
    assign chanTick[c] = genTick[routeSel[c]];
  end
endmodule

// File: rtl/brg_bank.sv
module brg_bank
  import brg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clkEn,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [REG_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [REG_W-1:0]      rdData,
  output logic [GEN_COUNT-1:0]  genTick,
  output logic [CHAN_COUNT-1:0] chanTick
);
  brgStrobes_t strobes;
  divVal_t     divisor [GEN_COUNT];
  genSel_t     routeSel [CHAN_COUNT];

  brg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .strobes(strobes),
    .divisor(divisor), .routeSel(routeSel)
  );

  brg_datapath uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .divisor(divisor),
    .routeSel(routeSel), .genTick(genTick), .chanTick(chanTick)
  );
endmodule

// File: tb/tb_brg_bank.sv
`timescale 1ns/1ps
module tb_brg_bank;
  import brg_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clkEn = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic [3:0]        genTick;
  logic [3:0]        chanTick;

  int checks = 0;
  int failures = 0;
  int routeModel [4] = '{0, 0, 0, 0};
  bit finished = 0;

  brg_bank dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .genTick(genTick), .chanTick(chanTick)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // generator word: bit14 enable, bit13 prescale, bits[12:1] = N-1
  function automatic logic [31:0] cfg(input bit en, input bit pre, input int n);
    return (32'(en) << 14) | (32'(pre) << 13) | (32'(n - 1) << 1);
  endfunction

  task automatic wr(input int addr, input logic [31:0] data, input bit en);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(addr); wrData = data; clkEn = en;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; clkEn = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    rdAddr = ADDR_W'(addr);
    #1;
    data = rdData;
  endtask

  task automatic runGen(input int g, input int nEn, input int gap, input int chanIdx,
                        output int first, output int cnt, output int extra, output int chanCnt);
    int mism = 0;
    first = 0; cnt = 0; extra = 0; chanCnt = 0;
    for (int i = 1; i <= nEn; i++) begin
      clkEn = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clkEn = 1'b0;
      if (genTick[g]) begin
        cnt++;
        if (first == 0) first = i;
      end
      if (chanTick[chanIdx]) chanCnt++;
      for (int c = 0; c < 4; c++)
        if (chanTick[c] !== genTick[routeModel[c]]) mism++;
      for (int k = 0; k < gap; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (genTick[g]) extra++;
      end
    end
    check("R8", "routing mismatches during run", mism, 0);
  endtask

  task automatic tReset();
    logic [31:0] d;
    check("R1", "genTick after reset", genTick, 0);
    check("R1", "chanTick after reset", chanTick, 0);
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      check("R1", "register after reset", d, 0);
    end
  endtask

  task automatic tLayout();
    logic [31:0] d;
    wr(1, 32'hFFFF_FFFF, 1'b0);
    rd(1, d);
    check("R2", "generator word reserved bits", d, 32'h0000_7FFE);
    wr(4, 32'hFFFF_FFFF, 1'b0);
    rd(4, d);
    check("R8", "routing word reserved bits", d, 32'h0000_00FF);
    wr(4, 32'h0000_00E4, 1'b0);
    routeModel = '{0, 1, 2, 3};
    rd(4, d);
    check("R8", "routing readback", d, 32'h0000_00E4);
  endtask

  task automatic tPeriod();
    int f, n, x, cc;
    wr(0, cfg(1, 0, 4), 1'b0);
    runGen(0, 12, 0, 0, f, n, x, cc);
    check("R3", "N=4 first tick enable", f, 4);
    check("R3", "N=4 tick count in 12", n, 3);
    wr(0, cfg(1, 0, 1), 1'b0);
    runGen(0, 5, 0, 0, f, n, x, cc);
    check("R10", "N=1 first tick", f, 1);
    check("R10", "N=1 tick count in 5", n, 5);
    wr(3, cfg(1, 0, 4096), 1'b0);
    runGen(3, 4100, 0, 3, f, n, x, cc);
    check("R10", "N=4096 first tick", f, 4096);
    check("R10", "N=4096 tick count", n, 1);
  endtask

  task automatic tPrescale();
    int f, n, x, cc;
    wr(2, cfg(1, 1, 3), 1'b0);
    runGen(2, 100, 0, 2, f, n, x, cc);
    check("R4", "prescale N=3 first tick", f, 48);
    check("R4", "prescale N=3 count in 100", n, 2);
    wr(2, cfg(1, 1, 1), 1'b0);
    runGen(2, 40, 0, 2, f, n, x, cc);
    check("R4", "prescale N=1 first tick", f, 16);
    check("R4", "prescale N=1 count in 40", n, 2);
  endtask

  task automatic tDisable();
    int f, n, x, cc;
    wr(1, cfg(0, 0, 2), 1'b0);
    runGen(1, 20, 0, 1, f, n, x, cc);
    check("R5", "disabled generator ticks", n, 0);
  endtask

  task automatic tGaps();
    int f, n, x, cc;
    wr(0, cfg(1, 0, 5), 1'b0);
    runGen(0, 12, 2, 0, f, n, x, cc);
    check("R6", "gapped first tick enable", f, 5);
    check("R6", "gapped tick count", n, 2);
    check("R6", "ticks on idle cycles", x, 0);
  endtask

  task automatic tReload();
    int f, n, x, cc;
    wr(0, cfg(1, 0, 8), 1'b0);
    runGen(0, 5, 0, 0, f, n, x, cc);
    check("R7", "no tick before restart", n, 0);
    wr(0, cfg(1, 0, 8), 1'b0);
    runGen(0, 8, 0, 0, f, n, x, cc);
    check("R7", "first tick after mid-count rewrite", f, 8);
    wr(0, cfg(1, 0, 1), 1'b0);
    runGen(0, 2, 0, 0, f, n, x, cc);
    wr(0, cfg(1, 0, 1), 1'b1);
    check("R7", "tick after write with clkEn high", genTick[0], 0);
    runGen(0, 1, 0, 0, f, n, x, cc);
    check("R7", "tick resumes after write", f, 1);
  endtask

  task automatic tRoute();
    int f, n, x, cc;
    wr(4, 32'h0000_0043, 1'b0);
    routeModel = '{3, 0, 0, 1};
    wr(0, cfg(1, 0, 2), 1'b0);
    wr(3, cfg(1, 0, 3), 1'b0);
    wr(1, cfg(1, 0, 5), 1'b0);
    runGen(0, 30, 0, 0, f, n, x, cc);
    check("R9", "gen0 count alongside others", n, 15);
    check("R9", "gen0 first tick alongside others", f, 2);
    check("R8", "channel0 from gen3 count", cc, 10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLayout();
    tPeriod();
    tPrescale();
    tDisable();
    tGaps();
    tReload();
    tRoute();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule